// File: doc/BRIEF.md
# Three-Phase Sawtooth PWM Generator with Dead Time

This block produces three pairs of complementary PWM signals for an inverter bridge. An up-counter runs from zero to a programmed period value and then wraps, so the carrier is a sawtooth of period+1 clocks. Each of the three channels holds a duty value. A per-channel phase flip-flop is set when the counter is at zero and cleared when the counter equals the channel's compare value. Each phase flip-flop drives a positive and a negative output. Every turn-on edge of either output is delayed by a programmable dead time, so the two switches of a leg never conduct together.

The host writes duty values into buffers. The buffers are copied into the working compare registers only when the counter wraps, so a duty change never cuts a period short. A duty value above the period never matches, which holds the positive output on across whole periods. A duty of zero holds the negative output on. A one-clock pulse marks every period boundary. A polarity bit inverts all six outputs for gate drivers that are active low.

The carrier is a two-state machine. In CAR_IDLE the counter is zero and all outputs are inactive. The transition CAR_IDLE→CAR_RUN (start) fires on a 0→1 change of the enable bit, and it also loads the compare registers. The transition CAR_RUN→CAR_IDLE (stop) fires as soon as the enable bit reads 0. Each output has a three-state dead-band machine. In DB_OFF the output is off. DB_OFF→DB_WAIT (arm) or DB_OFF→DB_ON (fire, when the dead time is 0) happens on the first clock with the input high. In DB_WAIT the machine counts, and DB_WAIT→DB_ON (fire) happens once the dead time has elapsed. DB_ON is where the output is driven. Any state goes to DB_OFF (drop) as soon as the input falls.

Top module: `pwm3_gen`

## Requirements
- R1: With period register value P, the counter steps 0,1,…,P and returns to 0, and `period_irq` is high for exactly one clock when the counter holds P. Consecutive pulses are therefore P+1 clocks apart.
- R2: Counting starts on a 0→1 change of control bit 0 (enable). The first `period_irq` is high in the (P+2)-th clock cycle after the cycle in which the enabling write is presented.
- R3: While the enable bit is 0, the counter is held at 0, `period_irq` stays low and every output sits at its inactive level. The stop takes effect by the second clock after the disabling write.
- R4: A duty write to channel i (address 4+i) while running changes nothing in the current period. It takes effect from the period after the next wrap.
- R5: For a duty value d with DT+1 < d ≤ P, the positive output of the channel is active for d−(DT+1) clocks per period. For 0 ≤ d < P−DT, the negative output is active for P+1−d−(DT+1) clocks per period.
- R6: A duty value greater than P holds the positive output active and the negative output inactive for the full period, continuously across periods.
- R7: A duty value of 0 holds the positive output inactive and the negative output active for the full period.
- R8: The two outputs of a pair are never active in the same clock. Each output turns on DT+1 clocks after its partner turns off, where DT is the dead-time register (address 1).
- R9: An on-interval of DT+1 clocks or shorter is suppressed. For example, d = P with DT ≥ 0 gives no negative pulse, and d ≤ DT+1 gives no positive pulse.
- R10: Control bit 1 set selects active-low mode. All six outputs are inverted, including the idle level, and the timing is unchanged.
- R11: Register writes land on the clock edge where `wr_en` is high. Address 0 is the period, address 1 the dead time (low DT_W bits), address 2 the control register (bit 0 enable, bit 1 active-low), and addresses 4, 5, 6 are the duty buffers of channels 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W (16) | Register write data |
| pos_out | output | NUM_CH (3) | Positive-phase output per channel |
| neg_out | output | NUM_CH (3) | Negative-phase output per channel |
| period_irq | output | 1 | One-clock pulse at each period boundary |

## Verification
Each scenario counts the active clocks of all six outputs over whole carrier periods. Mid-range duties with a dead time of 2 separate correct compare-and-set timing from off-by-one errors on either edge. Duties of 0, above the period and equal to the period test the hold-on, hold-off and pulse-suppression paths. A dead time of 0 with duties of 1 and P shows whether a one-clock interval is dropped or leaks through. A duty rewrite in the middle of a period tells buffered reload apart from immediate reload. Start latency, disabling and the inverted-polarity pass check the state-machine transitions and the idle levels.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_PERIOD    = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DEAD      = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL      = 3'd2;
    localparam int unsigned       ADR_DUTY_BASE = 4;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_POL_BIT = 1;

    typedef enum logic [0:0] {
        CAR_IDLE = 1'b0,
        CAR_RUN  = 1'b1
    } car_state_e;

    typedef enum logic [1:0] {
        DB_OFF  = 2'd0,
        DB_WAIT = 2'd1,
        DB_ON   = 2'd2
    } db_state_e;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DT_W   = 8,
    parameter int unsigned NUM_CH = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    output logic [CNT_W-1:0]                 period,
    output logic [DT_W-1:0]                  dead,
    output logic                             cnt_en,
    output logic                             active_low,
    output logic [NUM_CH-1:0][CNT_W-1:0]     duty_buf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period     <= '0;
            dead       <= '0;
            cnt_en     <= 1'b0;
            active_low <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_PERIOD) begin
                period <= wr_data;
            end
            if (wr_addr == ADR_DEAD) begin
                dead <= wr_data[DT_W-1:0];
            end
            if (wr_addr == ADR_CTRL) begin
                cnt_en     <= wr_data[CTRL_EN_BIT];
                active_low <= wr_data[CTRL_POL_BIT];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
        localparam logic [ADDR_W-1:0] DUTY_ADR = ADDR_W'(ADR_DUTY_BASE + c);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                duty_buf[c] <= '0;
            end else if (wr_en && (wr_addr == DUTY_ADR)) begin
                duty_buf[c] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cnt_en,
    input  logic [CNT_W-1:0]             period,
    input  logic [NUM_CH-1:0][CNT_W-1:0] duty_buf,
    output car_state_e                   state,
    output logic [CNT_W-1:0]             cnt,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp,
    output logic                         run,
    output logic                         period_irq
);

    car_state_e state_nxt;
    logic       en_prev;
    logic       en_rise;
    logic       wrap;
    logic       load_cmp;

    assign en_rise = cnt_en & ~en_prev;
    assign wrap    = (state == CAR_RUN) && (cnt >= period);

    // transition logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CAR_IDLE: if (en_rise) state_nxt = CAR_RUN;   // start
            CAR_RUN:  if (!cnt_en) state_nxt = CAR_IDLE;  // stop
            default:  state_nxt = CAR_IDLE;
        endcase
    end

    // state register with counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CAR_IDLE;
            en_prev <= 1'b0;
            cnt     <= '0;
        end else begin
            state   <= state_nxt;
            en_prev <= cnt_en;
            if ((state == CAR_RUN) && cnt_en && !wrap) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    assign load_cmp = wrap || ((state == CAR_IDLE) && en_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (load_cmp) begin
            cmp <= duty_buf;
        end
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        period_irq = 1'b0;
        unique case (state)
            CAR_IDLE: begin
                run        = 1'b0;
                period_irq = 1'b0;
            end
            CAR_RUN: begin
                run        = 1'b1;
                period_irq = wrap;
            end
            default: begin
                run        = 1'b0;
                period_irq = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband
    import pwm3_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic [DT_W-1:0] dead,
    output logic            dout
);

    db_state_e       state;
    db_state_e       state_nxt;
    logic [DT_W-1:0] wait_cnt;
    logic [DT_W-1:0] wait_cnt_nxt;

    // transition logic
    always_comb begin
        state_nxt    = state;
        wait_cnt_nxt = wait_cnt;
        if (!din) begin
            state_nxt    = DB_OFF;                        // drop
            wait_cnt_nxt = '0;
        end else begin
            unique case (state)
                DB_OFF: begin
                    if (dead == '0) begin
                        state_nxt = DB_ON;                // fire
                    end else begin
                        state_nxt    = DB_WAIT;           // arm
                        wait_cnt_nxt = DT_W'(1);
                    end
                end
                DB_WAIT: begin
                    if (wait_cnt >= dead) begin
                        state_nxt = DB_ON;                // fire
                    end else begin
                        wait_cnt_nxt = wait_cnt + 1'b1;
                    end
                end
                DB_ON:   state_nxt = DB_ON;
                default: state_nxt = DB_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= DB_OFF;
            wait_cnt <= '0;
        end else begin
            state    <= state_nxt;
            wait_cnt <= wait_cnt_nxt;
        end
    end

    // outputs: the turn-off is immediate, the turn-on waits for DB_ON
    always_comb begin
        dout = 1'b0;
        unique case (state)
            DB_OFF:  dout = 1'b0;
            DB_WAIT: dout = 1'b0;
            DB_ON:   dout = din;
            default: dout = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dead,
    output logic             phase_ff,
    output logic             pos_act,
    output logic             neg_act
);

    logic pos_req;
    logic neg_req;

    // clear on compare match has priority over set at zero (0% duty)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_ff <= 1'b0;
        end else if (!run) begin
            phase_ff <= 1'b0;
        end else if (cnt == cmp) begin
            phase_ff <= 1'b0;
        end else if (cnt == '0) begin
            phase_ff <= 1'b1;
        end
    end

    assign pos_req = run & phase_ff;
    assign neg_req = run & ~phase_ff;

    pwm3_deadband #(.DT_W(DT_W)) u_db_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pos_req),
        .dead  (dead),
        .dout  (pos_act)
    );

    pwm3_deadband #(.DT_W(DT_W)) u_db_neg (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (neg_req),
        .dead  (dead),
        .dout  (neg_act)
    );

endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DT_W   = 8,
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pos_out,
    output logic [NUM_CH-1:0] neg_out,
    output logic              period_irq
);

    logic [CNT_W-1:0]             period;
    logic [DT_W-1:0]              dead;
    logic                         cnt_en;
    logic                         active_low;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    logic [CNT_W-1:0]             cnt;
    car_state_e                   car_state;
    logic                         run;
    logic [NUM_CH-1:0]            phase_ff;
    logic [NUM_CH-1:0]            pos_act;
    logic [NUM_CH-1:0]            neg_act;

    pwm3_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .period     (period),
        .dead       (dead),
        .cnt_en     (cnt_en),
        .active_low (active_low),
        .duty_buf   (duty_buf)
    );

    pwm3_carrier #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .period     (period),
        .duty_buf   (duty_buf),
        .state      (car_state),
        .cnt        (cnt),
        .cmp        (cmp),
        .run        (run),
        .period_irq (period_irq)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm3_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .cnt      (cnt),
            .cmp      (cmp[c]),
            .dead     (dead),
            .phase_ff (phase_ff[c]),
            .pos_act  (pos_act[c]),
            .neg_act  (neg_act[c])
        );
        assign pos_out[c] = pos_act[c] ^ active_low;
        assign neg_out[c] = neg_act[c] ^ active_low;
    end

endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input car_state_e                   car_state,
    input logic                         cnt_en,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             period,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp,
    input logic                         period_irq,
    input logic [NUM_CH-1:0]            pos_act,
    input logic [NUM_CH-1:0]            neg_act
);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_state == CAR_RUN && cnt_en && cnt < period) |=> (cnt == $past(cnt) + 1'b1));

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_state == CAR_RUN && cnt >= period) |=> (cnt == '0));

    // R1
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> (!period_irq || period == '0));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_state == CAR_IDLE) |-> (cnt == '0 && !period_irq && pos_act == '0 && neg_act == '0));

    // R4
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_state == CAR_RUN && cnt < period) |=> $stable(cmp));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
        // R8
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pos_act[c] && neg_act[c]));

        // R8
        gap_after_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(neg_act[c]) |-> !pos_act[c]);

        // R8
        gap_after_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pos_act[c]) |-> !neg_act[c]);
    end

endmodule

bind pwm3_gen pwm3_gen_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_pwm3_gen_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_state  (car_state),
    .cnt_en     (cnt_en),
    .cnt        (cnt),
    .period     (period),
    .cmp        (cmp),
    .period_irq (period_irq),
    .pos_act    (pos_act),
    .neg_act    (neg_act)
);

// File: tb/tb_pwm3_gen.sv
`timescale 1ns/1ps
module tb_pwm3_gen;

    localparam int P   = 19;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pos_out;
    logic [2:0]  neg_out;
    logic        period_irq;

    logic pol = 1'b0;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    pwm3_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pos_out    (pos_out),
        .neg_out    (neg_out),
        .period_irq (period_irq)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!period_irq && n < 1000);
    endtask

    task automatic set_duty(input int d0, input int d1, input int d2);
        wr(3'd4, d0);
        wr(3'd5, d1);
        wr(3'd6, d2);
    endtask

    // counts active clocks over k whole periods, starting right after a boundary
    task automatic measure(input string req, input int k, input int ep [3], input int en [3]);
        int pc [3];
        int nc [3];
        int ov = 0;
        int irqs = 0;
        logic [2:0] pa, na;
        for (int c = 0; c < NCH; c++) begin pc[c] = 0; nc[c] = 0; end
        wait_irq();
        wait_irq();
        wait_irq();
        for (int i = 0; i < k * (P + 1); i++) begin
            @(negedge clk);
            pa = pos_out ^ {3{pol}};
            na = neg_out ^ {3{pol}};
            for (int c = 0; c < NCH; c++) begin
                if (pa[c]) pc[c]++;
                if (na[c]) nc[c]++;
                if (pa[c] && na[c]) ov++;
            end
            if (period_irq) irqs++;
        end
        for (int c = 0; c < NCH; c++) begin
            check(req, $sformatf("ch%0d positive active clocks", c), pc[c], k * ep[c]);
            check(req, $sformatf("ch%0d negative active clocks", c), nc[c], k * en[c]);
        end
        check("R8", "overlapping active clocks", ov, 0);
        check("R1", "period pulses in window", irqs, k);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R3", "pos_out after reset", int'(pos_out), 0);
        check("R3", "neg_out after reset", int'(neg_out), 0);
        check("R3", "irq after reset", int'(period_irq), 0);
    endtask

    task automatic t_idle_config();
        int act = 0;
        int irqs = 0;
        wr(3'd0, P);                 // R11 period
        wr(3'd1, 2);                 // R11 dead time
        set_duty(5, 10, 15);         // R11 duty buffers
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pos_out != 0 || neg_out != 0) act++;
            if (period_irq) irqs++;
        end
        check("R3", "active samples while disabled", act, 0);
        check("R3", "irq while disabled", irqs, 0);
    endtask

    task automatic t_start();
        int n = 1;
        wr(3'd2, 1);
        while (!period_irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R2", "clocks from enable write to first irq", n, P + 2);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!period_irq && n < 1000);
        check("R1", "irq spacing", n, P + 1);
    endtask

    task automatic t_basic();
        measure("R5", 2, '{2, 7, 12}, '{12, 7, 2});
    endtask

    task automatic t_reload();
        int pc = 0;
        wait_irq();
        for (int i = 0; i <= P; i++) begin
            @(negedge clk);
            if (i == 2) begin
                wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'd6;
            end else begin
                wr_en = 1'b0;
            end
            if (pos_out[2] ^ pol) pc++;
        end
        wr_en = 1'b0;
        check("R4", "ch2 pulse in period of the write", pc, 12);
        pc = 0;
        for (int i = 0; i <= P; i++) begin
            @(negedge clk);
            if (pos_out[2] ^ pol) pc++;
        end
        check("R4", "ch2 pulse in next period", pc, 3);
    endtask

    task automatic t_extremes();
        set_duty(0, 25, P);
        // R7 ch0, R6 ch1, R9 ch2 (negative interval of one clock)
        measure("R6/R7/R9", 2, '{0, 20, 16}, '{20, 0, 0});
        set_duty(3, 1, 2);
        // R9: positive intervals of DT+1 clocks or fewer
        measure("R9", 1, '{0, 0, 0}, '{14, 16, 15});
    endtask

    task automatic t_dead0();
        wr(3'd1, 0);
        set_duty(1, 10, P);
        measure("R8", 2, '{0, 9, 18}, '{18, 9, 0});
    endtask

    task automatic t_polarity();
        int act = 0;
        int irqs = 0;
        wr(3'd1, 2);
        set_duty(5, 10, 15);
        wr(3'd2, 3);
        pol = 1'b1;
        measure("R10", 2, '{2, 7, 12}, '{12, 7, 2});
        wr(3'd2, 2);
        @(negedge clk);
        check("R10", "pos_out idle level active-low", int'(pos_out), 7);
        check("R10", "neg_out idle level active-low", int'(neg_out), 7);
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (pos_out != 3'b111 || neg_out != 3'b111) act++;
            if (period_irq) irqs++;
        end
        check("R3", "active samples after disable", act, 0);
        check("R3", "irq after disable", irqs, 0);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_config();
        t_start();
        t_basic();
        t_reload();
        t_extremes();
        t_dead0();
        t_polarity();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule